// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of taking an exception in a processor that has branch delay slots. When the pipeline presents an accepted exception, it receives the kind of entry, the exception code, the PC of the faulting instruction and whether that instruction sat in a delay slot. In that same cycle it updates the saved return address, the cause code, the branch-delay flag, the debug cause bits and the mode flags. One cycle later it raises a redirect strobe for fetch, together with the vector address.

There are three entry paths, and each has its own return register and mode flag:
- **Normal** entries go to the exception PC and set the exception-level flag.
- **Reset-class** entries go to the error PC, set the error-level flag and reload the status word.
- **Debug** entries go to the debug PC, set debug mode and mark one debug cause bit.

An external interrupt that arrives while debug mode is active is treated as a debug interrupt. Fetch itself and the rest of the pipeline live outside this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every register output is zero: return registers, cause, status, debug bits, mode flags, `watch_clr`, `redirect` and `redirect_vec`.
- R2: The saved return address is `pc - 4` (modulo 2^32) when `in_delay_slot` is 1, and `pc` otherwise. This rule applies to `epc`, `error_epc` and `depc` alike. The only exception is R7.
- R3: A normal entry changes `cause` in two places only. Bits 6:2 receive the code: `exc_code` for kind 0, and 0 for kind 1. Bit 31 receives `in_delay_slot`. All other `cause` bits keep their value.
- R4: A normal entry writes `epc` and sets `exl`. It leaves `erl`, `dm`, `depc`, `error_epc`, `status` and `debug_cause` unchanged.
- R5: Kind 1 (external interrupt) accepted while `dm`=1 behaves as a debug interrupt. It writes `depc` and sets `debug_cause` bit 1. It leaves `cause`, `epc` and `exl` unchanged.
- R6: Debug kinds set a `debug_cause` bit, which is OR-ed into the bits already set, and they set `dm`. The mapping is: kind 3 (single step) to bit 0, kind 4 (debug interrupt) to bit 1, kind 5 (instruction break) to bit 2, kind 6 (breakpoint) to bit 3, kind 7 (data-break store) to bit 4, and kind 8 (data-break load) to bit 5. A debug entry leaves `exl` and `erl` unchanged.
- R7: A single-step entry (kind 3) saves `pc` itself into `depc`, whatever `in_delay_slot` says.
- R8: A reset-class entry (kind 2) does four things. It sets `status` to 0x10400000: bit 28 is coprocessor-0 usable, and bit 22 is the bootstrap-vector enable. It writes `error_epc`. It sets `erl`=1, `exl`=0 and `dm`=0. It pulses `watch_clr` for one cycle.
- R9: In the cycle after an accepted entry, `redirect` is 1 and `redirect_vec` holds the vector. For a reset-class entry the vector is 0xBFC00000. For a debug entry it is 0xBFC00480. For a normal entry it is 0xBFC00380 if `status` bit 22 was set at acceptance, and 0x80000180 otherwise.
- R10: A cycle with `exc_valid`=0, or with a kind code of 9 to 15, changes no register and leaves `redirect` and `watch_clr` at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception accepted this cycle |
| exc_kind | input | 4 | Entry kind code (see R3 to R8) |
| exc_code | input | 5 | Cause code for a general exception |
| pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a delay slot |
| epc | output | 32 | Normal return address |
| error_epc | output | 32 | Reset-class return address |
| depc | output | 32 | Debug return address |
| cause | output | 32 | Cause word (bit 31 delay flag, bits 6:2 code) |
| status | output | 32 | Status word |
| debug_cause | output | 6 | Debug cause bits |
| exl | output | 1 | Exception-level flag |
| erl | output | 1 | Error-level flag |
| dm | output | 1 | Debug mode flag |
| watch_clr | output | 1 | One-cycle watch clear pulse |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_vec | output | 32 | Vector address for the redirect |

## Verification
General exceptions are driven both in and out of a delay slot, so both the `pc - 4` path and the plain path are exercised. A delay-slot entry at PC 0 is included to show that the subtraction wraps. External interrupts are sent once with debug mode off and once with it on, which shows whether the conversion to a debug interrupt happens. Every debug kind is driven, including a single step inside a delay slot, which checks that single step skips the delay-slot adjustment. A reset-class entry comes between normal entries, so the bench sees the vector change with the bootstrap bit, and back-to-back accepts and unknown kind codes test the strobe timing and the ignore rule.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam int DBG_W  = 6;

    localparam int CAUSE_BD_BIT   = 31;
    localparam int CAUSE_CODE_LO  = 2;
    localparam int STATUS_CU0_BIT = 28;
    localparam int STATUS_BEV_BIT = 22;

    typedef enum logic [3:0] {
        EK_GENERAL = 4'd0,
        EK_EXT_INT = 4'd1,
        EK_RESET   = 4'd2,
        EK_DBG_SS  = 4'd3,
        EK_DBG_INT = 4'd4,
        EK_DBG_IB  = 4'd5,
        EK_DBG_BP  = 4'd6,
        EK_DBG_DBS = 4'd7,
        EK_DBG_DBL = 4'd8
    } exc_kind_e;

    typedef enum logic [1:0] {
        PATH_NONE   = 2'd0,
        PATH_NORMAL = 2'd1,
        PATH_ERROR  = 2'd2,
        PATH_DEBUG  = 2'd3
    } entry_path_e;

    typedef struct packed {
        entry_path_e       path;
        logic [CODE_W-1:0] code;
        logic [DBG_W-1:0]  dbg_bit;
        logic              no_adjust;
    } entry_dec_t;

    function automatic logic [XLEN-1:0] reset_status_word();
        logic [XLEN-1:0] w;
        w = '0;
        w[STATUS_CU0_BIT] = 1'b1;
        w[STATUS_BEV_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
#(
    parameter int KIND_W = 4
) (
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic [CODE_W-1:0] code_in,
    input  logic              in_debug,
    output entry_dec_t        dec
);
    localparam int DBG_FIRST = int'(EK_DBG_SS);

    always_comb begin
        dec = '{path: PATH_NONE, code: '0, dbg_bit: '0, no_adjust: 1'b0};
        if (valid) begin
            if (kind == KIND_W'(EK_GENERAL)) begin
                dec.path = PATH_NORMAL;
                dec.code = code_in;
            end else if (kind == KIND_W'(EK_EXT_INT)) begin
                if (in_debug) begin
                    dec.path = PATH_DEBUG;
                    dec.dbg_bit[int'(EK_DBG_INT) - DBG_FIRST] = 1'b1;
                end else begin
                    dec.path = PATH_NORMAL;
                    dec.code = '0;
                end
            end else if (kind == KIND_W'(EK_RESET)) begin
                dec.path = PATH_ERROR;
            end else begin
                for (int b = 0; b < DBG_W; b++) begin
                    if (kind == KIND_W'(DBG_FIRST + b)) begin
                        dec.path       = PATH_DEBUG;
                        dec.dbg_bit[b] = 1'b1;
                    end
                end
                dec.no_adjust = (kind == KIND_W'(EK_DBG_SS));
            end
        end
    end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [AW-1:0] pc,
    input  logic          in_slot,
    input  logic          no_adjust,
    output logic [AW-1:0] ret
);
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    always_comb begin
        if (in_slot && !no_adjust) ret = pc - STEP;
        else                       ret = pc;
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] VEC_RESET = 32'hBFC0_0000,
    parameter logic [AW-1:0] VEC_BOOT  = 32'hBFC0_0380,
    parameter logic [AW-1:0] VEC_NORM  = 32'h8000_0180,
    parameter logic [AW-1:0] VEC_DEBUG = 32'hBFC0_0480
) (
    input  entry_path_e   path,
    input  logic          boot_vec_en,
    output logic [AW-1:0] vec
);
    always_comb begin
        unique case (path)
            PATH_ERROR:  vec = VEC_RESET;
            PATH_DEBUG:  vec = VEC_DEBUG;
            PATH_NORMAL: vec = boot_vec_en ? VEC_BOOT : VEC_NORM;
            default:     vec = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int               AW        = XLEN,
    parameter int               KIND_W    = 4,
    parameter logic [XLEN-1:0]  VEC_RESET = 32'hBFC0_0000,
    parameter logic [XLEN-1:0]  VEC_BOOT  = 32'hBFC0_0380,
    parameter logic [XLEN-1:0]  VEC_NORM  = 32'h8000_0180,
    parameter logic [XLEN-1:0]  VEC_DEBUG = 32'hBFC0_0480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [KIND_W-1:0] exc_kind,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [AW-1:0]     pc,
    input  logic              in_delay_slot,
    output logic [AW-1:0]     epc,
    output logic [AW-1:0]     error_epc,
    output logic [AW-1:0]     depc,
    output logic [AW-1:0]     cause,
    output logic [AW-1:0]     status,
    output logic [DBG_W-1:0]  debug_cause,
    output logic              exl,
    output logic              erl,
    output logic              dm,
    output logic              watch_clr,
    output logic              redirect,
    output logic [AW-1:0]     redirect_vec
);
    localparam int CODE_HI = CAUSE_CODE_LO + CODE_W - 1;

    entry_dec_t    dec;
    logic [AW-1:0] ret_addr;
    logic [AW-1:0] vec_next;

    exc_classify #(.KIND_W(KIND_W)) u_classify (
        .valid    (exc_valid),
        .kind     (exc_kind),
        .code_in  (exc_code),
        .in_debug (dm),
        .dec      (dec)
    );

    exc_ret_addr #(.AW(AW), .INSN_BYTES(4)) u_ret (
        .pc        (pc),
        .in_slot   (in_delay_slot),
        .no_adjust (dec.no_adjust),
        .ret       (ret_addr)
    );

    exc_vector_sel #(
        .AW(AW), .VEC_RESET(VEC_RESET), .VEC_BOOT(VEC_BOOT),
        .VEC_NORM(VEC_NORM), .VEC_DEBUG(VEC_DEBUG)
    ) u_vec (
        .path        (dec.path),
        .boot_vec_en (status[STATUS_BEV_BIT]),
        .vec         (vec_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc          <= '0;
            error_epc    <= '0;
            depc         <= '0;
            cause        <= '0;
            status       <= '0;
            debug_cause  <= '0;
            exl          <= 1'b0;
            erl          <= 1'b0;
            dm           <= 1'b0;
            watch_clr    <= 1'b0;
            redirect     <= 1'b0;
            redirect_vec <= '0;
        end else begin
            redirect     <= (dec.path != PATH_NONE);
            redirect_vec <= vec_next;
            watch_clr    <= (dec.path == PATH_ERROR);
            unique case (dec.path)
                PATH_NORMAL: begin
                    epc                        <= ret_addr;
                    cause[CODE_HI:CAUSE_CODE_LO] <= dec.code;
                    cause[CAUSE_BD_BIT]        <= in_delay_slot;
                    exl                        <= 1'b1;
                end
                PATH_ERROR: begin
                    error_epc <= ret_addr;
                    status    <= reset_status_word();
                    erl       <= 1'b1;
                    exl       <= 1'b0;
                    dm        <= 1'b0;
                end
                PATH_DEBUG: begin
                    depc        <= ret_addr;
                    debug_cause <= debug_cause | dec.dbg_bit;
                    dm          <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             exc_valid,
    input logic [3:0]       exc_kind,
    input logic [31:0]      pc,
    input logic             in_delay_slot,
    input logic [31:0]      epc,
    input logic [31:0]      depc,
    input logic [31:0]      cause,
    input logic [31:0]      status,
    input logic [DBG_W-1:0] debug_cause,
    input logic             exl,
    input logic             erl,
    input logic             dm,
    input logic             redirect
);
    // R9: a strobe only follows an accepted entry
    a_r9_redirect_after_accept: assert property (@(posedge clk) disable iff (rst)
        redirect |-> $past(exc_valid));

    // R2, R3: delay-slot general exception
    a_r3_delay_slot_normal: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind == 4'd0 && in_delay_slot)
        |=> (cause[31] && exl && epc == $past(pc) - 32'd4));

    // R7: single step ignores the delay slot
    a_r7_single_step_pc: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind == 4'd3) |=> (dm && depc == $past(pc) && debug_cause[0]));

    // R8: reset-class mode and status
    a_r8_reset_class: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind == 4'd2)
        |=> (erl && !exl && !dm && status == 32'h1040_0000));

    // R5: interrupt during debug mode leaves the cause word alone
    a_r5_dint_conversion: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind == 4'd1 && dm)
        |=> (debug_cause[1] && $stable(cause) && $stable(exl)));

    // R10: an idle cycle changes nothing
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> (!redirect && $stable(epc) && $stable(depc) && $stable(cause)));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .pc(pc), .in_delay_slot(in_delay_slot), .epc(epc), .depc(depc),
    .cause(cause), .status(status), .debug_cause(debug_cause),
    .exl(exl), .erl(erl), .dm(dm), .redirect(redirect)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_kind = '0;
    logic [4:0]  exc_code = '0;
    logic [31:0] pc = '0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] epc, error_epc, depc, cause, status, redirect_vec;
    logic [5:0]  debug_cause;
    logic        exl, erl, dm, watch_clr, redirect;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_epc, m_eepc, m_depc, m_cause, m_status, m_vec;
    logic [5:0]  m_dbg;
    logic        m_exl, m_erl, m_dm, m_wclr, m_redir;

    always #4 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_kind(exc_kind),
        .exc_code(exc_code), .pc(pc), .in_delay_slot(in_delay_slot),
        .epc(epc), .error_epc(error_epc), .depc(depc), .cause(cause),
        .status(status), .debug_cause(debug_cause), .exl(exl), .erl(erl),
        .dm(dm), .watch_clr(watch_clr), .redirect(redirect),
        .redirect_vec(redirect_vec)
    );

    always @(posedge clk) begin
        logic [31:0] ra;
        ra = in_delay_slot ? pc - 32'd4 : pc;
        if (rst) begin
            m_epc = 0; m_eepc = 0; m_depc = 0; m_cause = 0; m_status = 0;
            m_vec = 0; m_dbg = 0; m_exl = 0; m_erl = 0; m_dm = 0;
            m_wclr = 0; m_redir = 0;
        end else begin
            m_redir = 0; m_wclr = 0; m_vec = 0;
            if (exc_valid) begin
                if (exc_kind == 4'd0 || (exc_kind == 4'd1 && !m_dm)) begin
                    m_redir = 1;
                    m_vec = m_status[22] ? 32'hBFC0_0380 : 32'h8000_0180;
                    m_epc = ra;
                    m_cause[6:2] = (exc_kind == 4'd0) ? exc_code : 5'd0;
                    m_cause[31] = in_delay_slot;
                    m_exl = 1;
                end else if (exc_kind == 4'd2) begin
                    m_redir = 1; m_wclr = 1; m_vec = 32'hBFC0_0000;
                    m_eepc = ra; m_status = 32'h1040_0000;
                    m_erl = 1; m_exl = 0; m_dm = 0;
                end else if (exc_kind == 4'd1 || (exc_kind >= 4'd3 && exc_kind <= 4'd8)) begin
                    m_redir = 1; m_vec = 32'hBFC0_0480;
                    m_depc = (exc_kind == 4'd3) ? pc : ra;
                    m_dbg[(exc_kind == 4'd1) ? 1 : (exc_kind - 3)] = 1'b1;
                    m_dm = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2/R4", "epc", epc, m_epc);
            chk("R2/R8", "error_epc", error_epc, m_eepc);
            chk("R2/R7", "depc", depc, m_depc);
            chk("R3/R5", "cause", cause, m_cause);
            chk("R8", "status", status, m_status);
            chk("R6", "debug_cause", 32'(debug_cause), 32'(m_dbg));
            chk("R4", "exl", 32'(exl), 32'(m_exl));
            chk("R8", "erl", 32'(erl), 32'(m_erl));
            chk("R6", "dm", 32'(dm), 32'(m_dm));
            chk("R8", "watch_clr", 32'(watch_clr), 32'(m_wclr));
            chk("R9/R10", "redirect", 32'(redirect), 32'(m_redir));
            if (m_redir) chk("R9", "redirect_vec", redirect_vec, m_vec);
        end
    end

    task automatic fire(input logic [3:0] k, input logic [4:0] c, input logic [31:0] p, input logic ds);
        @(negedge clk);
        exc_valid = 1; exc_kind = k; exc_code = c; pc = p; in_delay_slot = ds;
        @(negedge clk);
        exc_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, checked once directly
        chk("R1", "reset epc", epc, 32'h0);
        chk("R1", "reset redirect", 32'(redirect), 32'h0);
        rst = 0;
        repeat (2) @(negedge clk);
        chk("R1", "post-reset status", status, 32'h0);
        // R3 R4 normal entries, plain and delay slot
        fire(4'd0, 5'd5, 32'h0040_0010, 1'b0);
        fire(4'd0, 5'd12, 32'h0040_0104, 1'b1);
        fire(4'd1, 5'd9, 32'h0040_0200, 1'b0);
        // R10: unknown kind and idle
        fire(4'd12, 5'd3, 32'h1234_5678, 1'b1);
        repeat (2) @(negedge clk);
        // R7: single step in delay slot
        fire(4'd3, 5'd0, 32'h0040_0300, 1'b1);
        // R5: interrupt while in debug mode
        fire(4'd1, 5'd0, 32'h0040_0404, 1'b1);
        // R6: each remaining debug kind
        fire(4'd5, 5'd0, 32'h0040_0500, 1'b0);
        fire(4'd6, 5'd0, 32'h0040_0600, 1'b1);
        fire(4'd7, 5'd0, 32'h0040_0700, 1'b0);
        fire(4'd8, 5'd0, 32'h0040_0800, 1'b1);
        fire(4'd4, 5'd0, 32'h0040_0900, 1'b0);
        // R8: reset-class with delay slot
        fire(4'd2, 5'd0, 32'h0040_0A08, 1'b1);
        // R9: normal vector with bootstrap bit, and PC wrap for R2
        fire(4'd0, 5'd4, 32'h0000_0000, 1'b1);
        // back-to-back accepts
        @(negedge clk);
        exc_valid = 1; exc_kind = 4'd0; exc_code = 5'd31; pc = 32'h8000_0020; in_delay_slot = 0;
        @(negedge clk);
        exc_kind = 4'd2; pc = 32'h8000_0024; in_delay_slot = 1;
        @(negedge clk);
        exc_valid = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        done = 1;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule